// File: doc/BRIEF.md
# Event Interrupt Line Router

This block takes one internal event interrupt request and steers it to exactly one of several system interrupt lines, or to a system-control interrupt (SCI) request, under the control of a small 8-bit configuration register. A 3-bit select field in the register picks the destination line. The same code also fixes the electrical sense of the drive. The three low lines are asserted high. The four upper lines are asserted low, so that other sources can share them in wired fashion. A separate enable bit gates the whole path.

The four upper lines can only be used while the system runs with the advanced interrupt controller enabled (the `apic_mode` input). An external steering input (`sci_steer`) overrides the select field and sends the request out as an SCI instead. All route outputs come from flops. A new configuration therefore reaches the pins one clock edge after the register write, and the outputs do not glitch.

Top module: `evt_irq_router`

## Requirements
- R1: After reset the register reads 0x00, `irq_hi` is 3'b000, `irq_lo_n` is 4'b1111 and `sci_req` is 0.
- R2: A write stores bit 3 (enable) and bits 2:0 (select); bits 7:4 ignore the written value and always read back as 0.
- R3: While the enable bit is 0, no line is driven and `sci_req` stays 0, whatever the other inputs are.
- R4: With enable set, `sci_steer` low and `evt_req` high, select code 0, 1 or 2 drives `irq_hi[code]` high, where bit 0 is the first low line. Without a request, every output stays inactive.
- R5: With enable set, `sci_steer` low, `evt_req` high and `apic_mode` high, select code 4 to 7 drives `irq_lo_n[code-4]` low.
- R6: Select code 3 drives no line. Codes 4 to 7 drive no line while `apic_mode` is low.
- R7: With enable set and `sci_steer` high, `sci_req` follows `evt_req`, and no line is driven for any select code.
- R8: Every output shows the configuration and inputs sampled at the previous rising clock edge, so a register write takes effect at the pins one edge after the write edge.
- R9: At no time is more than one of the eight destinations (three high lines, four low lines, SCI) active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data |
| evt_req | input | 1 | Raw internal interrupt request, active high |
| apic_mode | input | 1 | High when the advanced interrupt controller is in use |
| sci_steer | input | 1 | Forces delivery as SCI and ignores the select field |
| irq_hi | output | 3 | Active-high drives for the three low lines |
| irq_lo_n | output | 4 | Active-low drives for the four upper lines |
| sci_req | output | 1 | SCI request, active high |

## Verification
The embedded assertions check the following on every cycle:
- Reserved bits read as zero.
- A cleared enable blanks every output on the next edge.
- The SCI override suppresses all lines.
- An unusable code drives nothing.
- A usable upper-line code pulls exactly its own line low.
- At most one destination is active at a time.

Some behaviour only the bench scenarios can show: the mapping of each select code to its specific high-side line, the one-edge delay from a register write to the pins, and the full reset image.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int CFG_W    = 8;
  localparam int SEL_W    = 3;
  localparam int EN_BIT   = 3;
  localparam int HI_LINES = 3;
  localparam int LO_LINES = 4;
  localparam int LO_BASE  = 4;

  // A code is usable if it names a high-side line, or an upper line while APIC mode is on.
  function automatic logic code_usable(input logic [SEL_W-1:0] sel, input logic apic);
    int s;
    s = int'(sel);
    return (s < HI_LINES) || (apic && (s >= LO_BASE) && (s < LO_BASE + LO_LINES));
  endfunction

  // Read image: reserved bits are always zero.
  function automatic logic [CFG_W-1:0] cfg_view(input logic en, input logic [SEL_W-1:0] sel);
    logic [CFG_W-1:0] v;
    v = '0;
    v[EN_BIT] = en;
    v[SEL_W-1:0] = sel;
    return v;
  endfunction
endpackage

// File: rtl/evt_irq_cfg_reg.sv
module evt_irq_cfg_reg
  import evt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic             en_q,
  output logic [SEL_W-1:0] sel_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (we) begin
      en_q  <= wdata[EN_BIT];
      sel_q <= wdata[SEL_W-1:0];
    end
  end

  assign rdata = cfg_view(en_q, sel_q);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[CFG_W-1:EN_BIT+1] == '0);
endmodule

// File: rtl/evt_irq_route_dec.sv
module evt_irq_route_dec
  import evt_irq_pkg::*;
(
  input  logic                en,
  input  logic [SEL_W-1:0]    sel,
  input  logic                apic,
  input  logic                sci,
  input  logic                req,
  output logic                line_go,
  output logic [HI_LINES-1:0] hi_nxt,
  output logic [LO_LINES-1:0] lo_nxt_n,
  output logic                sci_nxt
);
  logic fire;

  assign fire    = en & req;
  assign sci_nxt = fire & sci;
  assign line_go = fire & ~sci & code_usable(sel, apic);

  for (genvar i = 0; i < HI_LINES; i++) begin : g_hi
    assign hi_nxt[i] = line_go && (int'(sel) == i);
  end

  for (genvar j = 0; j < LO_LINES; j++) begin : g_lo
    assign lo_nxt_n[j] = !(line_go && (int'(sel) == LO_BASE + j));
  end
endmodule

// File: rtl/evt_irq_out_reg.sv
module evt_irq_out_reg
  import evt_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HI_LINES-1:0] hi_nxt,
  input  logic [LO_LINES-1:0] lo_nxt_n,
  input  logic                sci_nxt,
  output logic [HI_LINES-1:0] hi_q,
  output logic [LO_LINES-1:0] lo_q_n,
  output logic                sci_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q_n <= '1;
      sci_q  <= 1'b0;
    end else begin
      hi_q   <= hi_nxt;
      lo_q_n <= lo_nxt_n;
      sci_q  <= sci_nxt;
    end
  end
endmodule

// File: rtl/evt_irq_router.sv
module evt_irq_router
  import evt_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [CFG_W-1:0]    cfg_wdata,
  output logic [CFG_W-1:0]    cfg_rdata,
  input  logic                evt_req,
  input  logic                apic_mode,
  input  logic                sci_steer,
  output logic [HI_LINES-1:0] irq_hi,
  output logic [LO_LINES-1:0] irq_lo_n,
  output logic                sci_req
);
  logic                en_q;
  logic [SEL_W-1:0]    sel_q;
  logic                line_go;
  logic [HI_LINES-1:0] hi_nxt;
  logic [LO_LINES-1:0] lo_nxt_n;
  logic                sci_nxt;
  logic                outs_idle;

  evt_irq_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en_q(en_q), .sel_q(sel_q)
  );

  evt_irq_route_dec u_dec (
    .en(en_q), .sel(sel_q), .apic(apic_mode), .sci(sci_steer), .req(evt_req),
    .line_go(line_go), .hi_nxt(hi_nxt), .lo_nxt_n(lo_nxt_n), .sci_nxt(sci_nxt)
  );

  evt_irq_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .hi_nxt(hi_nxt), .lo_nxt_n(lo_nxt_n), .sci_nxt(sci_nxt),
    .hi_q(irq_hi), .lo_q_n(irq_lo_n), .sci_q(sci_req)
  );

  assign outs_idle = (irq_hi == '0) && (&irq_lo_n) && !sci_req;

  a_r3_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> outs_idle);

  a_r7_sci_override: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && sci_steer && evt_req) |=> (sci_req && irq_hi == '0 && &irq_lo_n));

  a_r6_unusable_code: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !sci_steer && ((int'(sel_q) == HI_LINES) || (sel_q[SEL_W-1] && !apic_mode)))
    |=> outs_idle);

  a_r5_upper_low: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && evt_req && !sci_steer && apic_mode && sel_q[SEL_W-1])
    |=> (!irq_lo_n[$past(sel_q[1:0])] && $countones(~irq_lo_n) == 1 && irq_hi == '0));

  a_r9_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(irq_hi) + $countones(~irq_lo_n) + int'(sci_req)) <= 1);

  a_r8_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
    line_go |=> !outs_idle);
endmodule

// File: tb/test_evt_irq_router.sv
module test_evt_irq_router;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 15;
  localparam int  WATCHDOG = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       evt_req = 1'b0;
  logic       apic_mode = 1'b0;
  logic       sci_steer = 1'b0;
  logic [2:0] irq_hi;
  logic [3:0] irq_lo_n;
  logic       sci_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_router i_evt_irq_router (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .evt_req(evt_req), .apic_mode(apic_mode), .sci_steer(sci_steer),
    .irq_hi(irq_hi), .irq_lo_n(irq_lo_n), .sci_req(sci_req)
  );

  // Vector: [22:19] req id, [18:11] ctrl, [10] apic, [9] sci, [8] evt, [7:5] hi, [4:1] lo_n, [0] sci
  localparam logic [22:0] VEC [NVEC] = '{
    {4'd4, 8'h08, 1'b0, 1'b0, 1'b1, 3'b001, 4'hF, 1'b0}, // R4 code 0
    {4'd4, 8'h09, 1'b0, 1'b0, 1'b1, 3'b010, 4'hF, 1'b0}, // R4 code 1
    {4'd4, 8'h0A, 1'b1, 1'b0, 1'b1, 3'b100, 4'hF, 1'b0}, // R4 code 2
    {4'd6, 8'h0B, 1'b1, 1'b0, 1'b1, 3'b000, 4'hF, 1'b0}, // R6 code 3
    {4'd5, 8'h0C, 1'b1, 1'b0, 1'b1, 3'b000, 4'hE, 1'b0}, // R5 code 4
    {4'd5, 8'h0D, 1'b1, 1'b0, 1'b1, 3'b000, 4'hD, 1'b0}, // R5 code 5
    {4'd5, 8'h0E, 1'b1, 1'b0, 1'b1, 3'b000, 4'hB, 1'b0}, // R5 code 6
    {4'd5, 8'h0F, 1'b1, 1'b0, 1'b1, 3'b000, 4'h7, 1'b0}, // R5 code 7
    {4'd6, 8'h0C, 1'b0, 1'b0, 1'b1, 3'b000, 4'hF, 1'b0}, // R6 code 4 no apic
    {4'd6, 8'h0F, 1'b0, 1'b0, 1'b1, 3'b000, 4'hF, 1'b0}, // R6 code 7 no apic
    {4'd3, 8'h02, 1'b1, 1'b0, 1'b1, 3'b000, 4'hF, 1'b0}, // R3 disabled
    {4'd7, 8'h0D, 1'b1, 1'b1, 1'b1, 3'b000, 4'hF, 1'b1}, // R7 override
    {4'd3, 8'h01, 1'b1, 1'b1, 1'b1, 3'b000, 4'hF, 1'b0}, // R3 disabled with override
    {4'd4, 8'h0A, 1'b0, 1'b0, 1'b0, 3'b000, 4'hF, 1'b0}, // R4 no request
    {4'd2, 8'hF9, 1'b0, 1'b0, 1'b1, 3'b010, 4'hF, 1'b0}  // R2 reserved bits ignored
  };

  task automatic check_out(input string tag, input logic [2:0] hi, input logic [3:0] lo_n, input logic sci);
    checks++;
    if (irq_hi !== hi || irq_lo_n !== lo_n || sci_req !== sci) begin
      failures++;
      $display("FAIL %s: got hi=%b lo_n=%b sci=%b expected hi=%b lo_n=%b sci=%b",
               tag, irq_hi, irq_lo_n, sci_req, hi, lo_n, sci);
    end
  endtask

  task automatic check_rd(input string tag, input logic [7:0] exp);
    checks++;
    if (cfg_rdata !== exp) begin
      failures++;
      $display("FAIL %s: got rdata=%h expected %h", tag, cfg_rdata, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      failures++;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset image, sampled while still in reset and just after release
    check_out("R1 reset outputs", 3'b000, 4'hF, 1'b0);
    check_rd("R1 reset register", 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R1 after release", 3'b000, 4'hF, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      cfg_we    = 1'b1;
      cfg_wdata = VEC[k][18:11];
      apic_mode = VEC[k][10];
      sci_steer = VEC[k][9];
      evt_req   = VEC[k][8];
      @(posedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      check_out($sformatf("R%0d vector %0d", VEC[k][22:19], k), VEC[k][7:5], VEC[k][4:1], VEC[k][0]);
    end

    // R2: reserved bits read as zero
    cfg_we = 1'b1; cfg_wdata = 8'hFF;
    @(negedge clk);
    cfg_we = 1'b0;
    check_rd("R2 readback of 0xFF", 8'h0F);
    cfg_we = 1'b1; cfg_wdata = 8'hA5;
    @(negedge clk);
    cfg_we = 1'b0;
    check_rd("R2 readback of 0xA5", 8'h05);

    // R8: a write reaches the pins one edge after the write edge
    cfg_we = 1'b1; cfg_wdata = 8'h00; evt_req = 1'b1; apic_mode = 1'b0; sci_steer = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check_out("R8 idle before write", 3'b000, 4'hF, 1'b0);
    cfg_we = 1'b1; cfg_wdata = 8'h08;
    @(negedge clk);
    cfg_we = 1'b0;
    check_out("R8 unchanged at write edge", 3'b000, 4'hF, 1'b0);
    @(negedge clk);
    check_out("R8 active one edge later", 3'b001, 4'hF, 1'b0);
    evt_req = 1'b0;
    @(negedge clk);
    check_out("R8 request drop one edge later", 3'b000, 4'hF, 1'b0);

    // R9: only one destination while switching from an upper line to the override
    cfg_we = 1'b1; cfg_wdata = 8'h0E; evt_req = 1'b1; apic_mode = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    @(negedge clk);
    check_out("R9 upper line 6", 3'b000, 4'hB, 1'b0);
    sci_steer = 1'b1;
    @(negedge clk);
    check_out("R9 override takes over", 3'b000, 4'hF, 1'b1);

    // R1: reset again clears an active state
    rst_n = 1'b0;
    #1;
    check_out("R1 async reset", 3'b000, 4'hF, 1'b0);
    check_rd("R1 async reset register", 8'h00);

    done = 1;
    finish_run();
  end
endmodule